// File: doc/BRIEF.md
# SPI Flash Command Sequencer

This block is a master-side controller for a serial flash or serial RAM device on a single-bit SPI bus. The host asks for one of four operations: read the identification word, erase a 4 KiB sector, read 1 to 4 bytes, or program 1 to 4 bytes. The block expands each request into the command frames the device needs and drives SCLK, chip select and MOSI in SPI mode 0. It samples MISO and returns the received bits right-aligned with a one-cycle completion strobe.

Erase and program requests are always preceded by their own write-enable frame. After the operation frame, the block polls the 16-bit status word until the busy flag clears. A mode input picks a 24-bit address phase for flash parts or a 16-bit phase for RAM-type parts. RAM-type programs skip the status polling. The SCLK period is a parameter, 2·HALF_DIV system clocks, which gives a ratio of 8 by default.

Top module: `sfc_seq`

## Requirements
- R1: An identify request (reqOp = 0) sends one frame: opcode 0x90, 24 zero address bits, then 16 input bits. rdData ends as {16'b0, manufacturer byte, device byte}, taken from the first and second received bytes.
- R2: Every erase and every program starts with a separate 8-bit frame that carries only opcode 0x06.
- R3: An erase request (reqOp = 1) takes the sector number from reqAddr[11:0]. It sends opcode 0x20 and the 24-bit address sector·4096. reqAddr[31:12] is ignored.
- R4: After the frame of an erase, or of a program in 24-bit mode, the block repeats a status frame (opcode 0x05, then 16 input bits) until bit 8 of the captured 16-bit value is 0. Only then does it signal completion. The other status bits have no effect.
- R5: A read request (reqOp = 2) sends opcode 0x03 and the address, then takes in 8·n bits. The received bits are right-aligned in rdData. n is reqBytes for values 1 to 3, and 4 for any other value (0 or 4 to 7).
- R6: A program request (reqOp = 3) sends opcode 0x02 and the address, then the low 8·n bits of reqWdata. Bytes above n are never sent. Erase and program leave rdData unchanged.
- R7: With addr16Mode = 0, reads and programs send reqAddr[23:0]. With addr16Mode = 1 they send reqAddr[15:0] and a program finishes without any status poll. Identify and erase always use 24 address bits, and erase always polls.
- R8: SPI mode 0. SCLK is low whenever chip select is deasserted. MOSI changes only while SCLK is low, and bits go out MSB first. MISO is sampled on each rising edge. Within a frame, rising edges are exactly 2·HALF_DIV clocks apart.
- R9: Each frame has its own chip-select assertion. The first rising edge comes at least 2·HALF_DIV clocks after chip select falls. Chip select rises at least 2·HALF_DIV clocks after the last falling edge, and stays high at least 2·HALF_DIV clocks between frames.
- R10: reqAck is high in the same cycle as reqValid whenever the block is idle, and the request is accepted on that edge. While busy is high, requests get no ack and produce no frames. doneStb is a single-cycle pulse, after which busy falls.
- R11: During and right after reset: chip select high, SCLK low, busy, doneStb and reqAck low, rdData zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr16Mode | input | 1 | 1 selects a 16-bit address phase for reads and programs |
| reqValid | input | 1 | Host request strobe |
| reqOp | input | 2 | 0 identify, 1 erase sector, 2 read, 3 program |
| reqAddr | input | 32 | Byte address, or sector number in bits 11:0 for erase |
| reqWdata | input | 32 | Program data, right-aligned |
| reqBytes | input | 3 | Byte count 1..3; other values mean 4 |
| reqAck | output | 1 | Request accepted this cycle |
| busy | output | 1 | Operation in progress |
| doneStb | output | 1 | One-cycle completion pulse |
| rdData | output | 32 | Right-aligned result of the last identify or read |
| spiSclk | output | 1 | Serial clock |
| spiCsN | output | 1 | Active-low chip select |
| spiMosi | output | 1 | Serial data to the device |
| spiMiso | input | 1 | Serial data from the device |

## Verification
The bench builds the block with HALF_DIV = 2, so an SCLK period is four system clocks. With frames this short, the bench can sweep every byte count (including the out-of-range codes that fold to four) in both address modes for reads and programs. It can also run erases and programs against 0, 1, 2 and 3 busy status replies in one short run. A device model inside the bench records every frame bit by bit. It answers identify, read and status frames, and it measures setup, hold, gap and period between SCLK edges, so the bench checks framing as well as content.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

  typedef enum logic [1:0] {
    OP_IDENT = 2'd0,
    OP_ERASE = 2'd1,
    OP_READ  = 2'd2,
    OP_PROG  = 2'd3
  } hostOp_e;

  localparam logic [7:0] CMD_WREN   = 8'h06;
  localparam logic [7:0] CMD_ERASE  = 8'h20;
  localparam logic [7:0] CMD_READ   = 8'h03;
  localparam logic [7:0] CMD_PROG   = 8'h02;
  localparam logic [7:0] CMD_STATUS = 8'h05;
  localparam logic [7:0] CMD_IDENT  = 8'h90;

  localparam int BUSY_BIT    = 8;
  localparam int SECTOR_LOG2 = 12;

  // strobe bundle from the control FSM to the shift engine
  typedef struct packed {
    logic        start;
    logic [7:0]  opcode;
    logic [5:0]  addrBits;
    logic [23:0] addr;
    logic [5:0]  outBits;
    logic [31:0] outData;
    logic [5:0]  inBits;
  } frameCmd_t;

endpackage

// File: rtl/sfc_ctrl.sv
module sfc_ctrl
  import sfc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        addr16Mode,
  input  logic        reqValid,
  input  logic [1:0]  reqOp,
  input  logic [31:0] reqAddr,
  input  logic [31:0] reqWdata,
  input  logic [2:0]  reqBytes,
  output logic        reqAck,
  output logic        busy,
  output logic        doneStb,
  output logic [31:0] rdData,
  output frameCmd_t   cmd,
  input  logic        frameDone,
  input  logic [31:0] frameRx
);

  typedef enum logic [2:0] {
    C_IDLE, C_WREN, C_MAIN, C_POLL, C_DONE
  } ctrlState_e;

  ctrlState_e  state;
  logic        launched;
  hostOp_e     opReg;
  logic [23:0] addrReg;
  logic [31:0] dataReg;
  logic [2:0]  nbReg;
  logic        m16Reg;
  logic [31:0] rdReg;

  logic [2:0]  nbEff;
  logic [5:0]  addrBitsSel;
  logic [5:0]  dataBits;
  logic [31:0] dataMasked;
  logic        unusedAddrHi;

  assign unusedAddrHi = ^reqAddr[31:24];

  // byte count folding: only 1..3 are taken literally
  assign nbEff = (reqBytes >= 3'd1 && reqBytes <= 3'd3) ? reqBytes : 3'd4;

  assign addrBitsSel = m16Reg ? 6'd16 : 6'd24;
  assign dataBits    = {nbReg, 3'b000};
  assign dataMasked  = dataReg & ~(32'hFFFF_FFFF << dataBits);

  assign reqAck  = reqValid && (state == C_IDLE);
  assign busy    = (state != C_IDLE);
  assign doneStb = (state == C_DONE);
  assign rdData  = rdReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= C_IDLE;
      launched <= 1'b0;
      opReg    <= OP_IDENT;
      addrReg  <= '0;
      dataReg  <= '0;
      nbReg    <= 3'd4;
      m16Reg   <= 1'b0;
      rdReg    <= '0;
    end else begin
      case (state)
        C_IDLE: begin
          launched <= 1'b0;
          if (reqValid) begin
            opReg   <= hostOp_e'(reqOp);
            addrReg <= reqAddr[23:0];
            dataReg <= reqWdata;
            nbReg   <= nbEff;
            m16Reg  <= addr16Mode;
            if (hostOp_e'(reqOp) == OP_ERASE || hostOp_e'(reqOp) == OP_PROG)
              state <= C_WREN;
            else
              state <= C_MAIN;
          end
        end
        C_WREN, C_MAIN, C_POLL: begin
          if (frameDone) begin
            launched <= 1'b0;
            case (state)
              C_WREN: state <= C_MAIN;
              C_MAIN: begin
                if (opReg == OP_IDENT || opReg == OP_READ) rdReg <= frameRx;
                if (opReg == OP_ERASE || (opReg == OP_PROG && !m16Reg))
                  state <= C_POLL;
                else
                  state <= C_DONE;
              end
              default: begin
                if (!frameRx[BUSY_BIT]) state <= C_DONE;
              end
            endcase
          end else if (!launched) begin
            launched <= 1'b1;
          end
        end
        default: state <= C_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd       = '0;
    cmd.start = (state == C_WREN || state == C_MAIN || state == C_POLL) && !launched;
    case (state)
      C_WREN: cmd.opcode = CMD_WREN;
      C_POLL: begin
        cmd.opcode = CMD_STATUS;
        cmd.inBits = 6'd16;
      end
      C_MAIN: begin
        case (opReg)
          OP_IDENT: begin
            cmd.opcode   = CMD_IDENT;
            cmd.addrBits = 6'd24;
            cmd.inBits   = 6'd16;
          end
          OP_ERASE: begin
            cmd.opcode   = CMD_ERASE;
            cmd.addrBits = 6'd24;
            cmd.addr     = {addrReg[11:0], {SECTOR_LOG2{1'b0}}};
          end
          OP_READ: begin
            cmd.opcode   = CMD_READ;
            cmd.addrBits = addrBitsSel;
            cmd.addr     = addrReg;
            cmd.inBits   = dataBits;
          end
          default: begin
            cmd.opcode   = CMD_PROG;
            cmd.addrBits = addrBitsSel;
            cmd.addr     = addrReg;
            cmd.outBits  = dataBits;
            cmd.outData  = dataMasked;
          end
        endcase
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/sfc_shift.sv
module sfc_shift
  import sfc_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  frameCmd_t   cmd,
  input  logic        spiMiso,
  output logic        spiSclk,
  output logic        spiCsN,
  output logic        spiMosi,
  output logic        frameDone,
  output logic [31:0] rxData
);

  localparam int FULL_DIV = 2 * HALF_DIV;
  localparam int TICK_W   = (FULL_DIV > 2) ? $clog2(FULL_DIV) : 1;
  localparam logic [TICK_W-1:0] HALF_END = TICK_W'(HALF_DIV - 1);
  localparam logic [TICK_W-1:0] FULL_END = TICK_W'(FULL_DIV - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_HIGH, S_LOW, S_HOLD, S_GAP
  } shiftState_e;

  shiftState_e       st;
  logic [TICK_W-1:0] tick;
  logic [63:0]       shiftReg;
  logic [6:0]        bitsLeft;
  logic [5:0]        inBitsReg;
  logic [31:0]       rx;
  logic              sclkReg;
  logic              csNReg;

  logic [31:0] addrAl;
  logic [31:0] dataAl;
  logic [63:0] frameVec;
  logic [6:0]  frameLen;
  logic        captureNow;

  // MSB-first packing: opcode, then address, then write data
  always_comb begin
    addrAl   = {8'h00, cmd.addr} << (6'd32 - cmd.addrBits);
    dataAl   = cmd.outData << (6'd32 - cmd.outBits);
    frameVec = {cmd.opcode, 56'b0}
             | ({addrAl, 32'b0} >> 8)
             | ({dataAl, 32'b0} >> (7'd8 + {1'b0, cmd.addrBits}));
    frameLen = 7'd8 + {1'b0, cmd.addrBits} + {1'b0, cmd.outBits} + {1'b0, cmd.inBits};
  end

  assign captureNow = (bitsLeft <= {1'b0, inBitsReg});

  assign spiSclk = sclkReg;
  assign spiCsN  = csNReg;
  assign spiMosi = shiftReg[63];
  assign rxData  = rx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st        <= S_IDLE;
      tick      <= '0;
      shiftReg  <= '0;
      bitsLeft  <= '0;
      inBitsReg <= '0;
      rx        <= '0;
      sclkReg   <= 1'b0;
      csNReg    <= 1'b1;
      frameDone <= 1'b0;
    end else begin
      frameDone <= 1'b0;
      case (st)
        S_IDLE: begin
          tick <= '0;
          if (cmd.start) begin
            shiftReg  <= frameVec;
            bitsLeft  <= frameLen;
            inBitsReg <= cmd.inBits;
            rx        <= '0;
            csNReg    <= 1'b0;
            st        <= S_SETUP;
          end
        end
        S_SETUP: begin
          if (tick == FULL_END) begin
            tick    <= '0;
            sclkReg <= 1'b1;
            st      <= S_HIGH;
            if (captureNow) rx <= {rx[30:0], spiMiso};
          end else begin
            tick <= tick + 1'b1;
          end
        end
        S_HIGH: begin
          if (tick == HALF_END) begin
            tick    <= '0;
            sclkReg <= 1'b0;
            if (bitsLeft == 7'd1) begin
              st <= S_HOLD;
            end else begin
              shiftReg <= {shiftReg[62:0], 1'b0};
              bitsLeft <= bitsLeft - 7'd1;
              st       <= S_LOW;
            end
          end else begin
            tick <= tick + 1'b1;
          end
        end
        S_LOW: begin
          if (tick == HALF_END) begin
            tick    <= '0;
            sclkReg <= 1'b1;
            st      <= S_HIGH;
            if (captureNow) rx <= {rx[30:0], spiMiso};
          end else begin
            tick <= tick + 1'b1;
          end
        end
        S_HOLD: begin
          if (tick == FULL_END) begin
            tick   <= '0;
            csNReg <= 1'b1;
            st     <= S_GAP;
          end else begin
            tick <= tick + 1'b1;
          end
        end
        default: begin
          if (tick == FULL_END) begin
            tick      <= '0;
            frameDone <= 1'b1;
            st        <= S_IDLE;
          end else begin
            tick <= tick + 1'b1;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/sfc_seq.sv
module sfc_seq
  import sfc_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        addr16Mode,
  input  logic        reqValid,
  input  logic [1:0]  reqOp,
  input  logic [31:0] reqAddr,
  input  logic [31:0] reqWdata,
  input  logic [2:0]  reqBytes,
  output logic        reqAck,
  output logic        busy,
  output logic        doneStb,
  output logic [31:0] rdData,
  output logic        spiSclk,
  output logic        spiCsN,
  output logic        spiMosi,
  input  logic        spiMiso
);

  frameCmd_t   cmd;
  logic        frameDone;
  logic [31:0] frameRx;

  sfc_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .addr16Mode (addr16Mode),
    .reqValid   (reqValid),
    .reqOp      (reqOp),
    .reqAddr    (reqAddr),
    .reqWdata   (reqWdata),
    .reqBytes   (reqBytes),
    .reqAck     (reqAck),
    .busy       (busy),
    .doneStb    (doneStb),
    .rdData     (rdData),
    .cmd        (cmd),
    .frameDone  (frameDone),
    .frameRx    (frameRx)
  );

  sfc_shift #(.HALF_DIV(HALF_DIV)) u_shift (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .spiMiso   (spiMiso),
    .spiSclk   (spiSclk),
    .spiCsN    (spiCsN),
    .spiMosi   (spiMosi),
    .frameDone (frameDone),
    .rxData    (frameRx)
  );

endmodule

// File: rtl/sfc_seq_chk.sv
module sfc_seq_chk (
  input logic clk,
  input logic rstN,
  input logic reqAck,
  input logic busy,
  input logic doneStb,
  input logic spiSclk,
  input logic spiCsN,
  input logic spiMosi
);

  p_sclk_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    spiCsN |-> !spiSclk);

  p_mosi_stable_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!spiCsN && spiSclk) |-> $stable(spiMosi));

  p_rise_in_frame_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(spiSclk) |-> (!spiCsN && $past(!spiCsN)));

  p_cs_fall_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(spiCsN) |=> (!spiCsN && !spiSclk));

  p_cs_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> spiCsN);

  p_ack_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |=> busy);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    doneStb |=> (!doneStb && !busy));

endmodule

bind sfc_seq sfc_seq_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .reqAck  (reqAck),
  .busy    (busy),
  .doneStb (doneStb),
  .spiSclk (spiSclk),
  .spiCsN  (spiCsN),
  .spiMosi (spiMosi)
);

// File: tb/sfc_seq_bench.sv
module sfc_seq_bench;

  localparam int HD   = 2;
  localparam int FULL = 2 * HD;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        addr16Mode = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqOp = 2'd0;
  logic [31:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic [2:0]  reqBytes = 3'd1;
  logic        reqAck, busy, doneStb;
  logic [31:0] rdData;
  logic        spiSclk, spiCsN, spiMosi;
  logic        spiMiso;

  always #5 clk = ~clk;

  sfc_seq #(.HALF_DIV(HD)) u_sfc_seq (
    .clk(clk), .rstN(rstN), .addr16Mode(addr16Mode), .reqValid(reqValid),
    .reqOp(reqOp), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqBytes(reqBytes),
    .reqAck(reqAck), .busy(busy), .doneStb(doneStb), .rdData(rdData),
    .spiSclk(spiSclk), .spiCsN(spiCsN), .spiMosi(spiMosi), .spiMiso(spiMiso)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // ---------------- device model ----------------
  int           bitIdx = 0;
  logic [127:0] cap = '0;
  logic [7:0]   curOp = '0;
  int           busyLeft = 0;
  logic [31:0]  readWord = '0;
  logic [15:0]  idWord = '0;
  logic [127:0] logBits [16];
  int           logLen [16];
  int           frameCnt = 0;
  int           cyc = 0;
  logic         prevCs = 1'b1, prevSclk = 1'b0;
  int csFallCyc = 0, csRiseCyc = 0, lastRise = 0, lastFall = 0;
  bit firstRise = 0, seenRise = 0;
  int minSetup = 1000000, minHold = 1000000, minGap = 1000000;
  int minPer = 1000000, maxPer = 0;

  always_comb begin
    int j;
    logic [15:0] statWord;
    statWord = (busyLeft > 0) ? 16'h0100 : 16'hFEFF;
    spiMiso = 1'b0;
    j = 0;
    if (bitIdx >= 8) begin
      case (curOp)
        8'h05: begin j = bitIdx - 8;  if (j < 16) spiMiso = statWord[15-j]; end
        8'h90: begin j = bitIdx - 32; if (j >= 0 && j < 16) spiMiso = idWord[15-j]; end
        8'h03: begin
          j = bitIdx - 8 - (addr16Mode ? 16 : 24);
          if (j >= 0 && j < 32) spiMiso = readWord[31-j];
        end
        default: spiMiso = 1'b0;
      endcase
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (prevCs && !spiCsN) begin
      bitIdx = 0; cap = '0; curOp = '0; firstRise = 1;
      csFallCyc = cyc;
      if (seenRise && (cyc - csRiseCyc) < minGap) minGap = cyc - csRiseCyc;
    end
    if (!prevSclk && spiSclk) begin
      if (firstRise) begin
        if ((cyc - csFallCyc) < minSetup) minSetup = cyc - csFallCyc;
        firstRise = 0;
      end else begin
        if ((cyc - lastRise) < minPer) minPer = cyc - lastRise;
        if ((cyc - lastRise) > maxPer) maxPer = cyc - lastRise;
      end
      lastRise = cyc;
      cap = {cap[126:0], spiMosi};
      if (bitIdx == 7) curOp = cap[7:0];
      bitIdx++;
    end
    if (prevSclk && !spiSclk) lastFall = cyc;
    if (!prevCs && spiCsN) begin
      if ((cyc - lastFall) < minHold) minHold = cyc - lastFall;
      if (frameCnt < 16) begin
        logBits[frameCnt] = cap;
        logLen[frameCnt]  = bitIdx;
      end
      frameCnt++;
      if (curOp == 8'h05 && busyLeft > 0) busyLeft--;
      csRiseCyc = cyc;
      seenRise  = 1;
    end
    prevCs   = spiCsN;
    prevSclk = spiSclk;
  end

  // ---------------- expected frames ----------------
  function automatic logic [127:0] mk(input logic [7:0] op, input int ab, input logic [31:0] a,
                                      input int ob, input logic [31:0] d, input int ib);
    logic [127:0] v;
    v = 128'(op);
    v = (v << ab) | (128'(a) & ((128'd1 << ab) - 128'd1));
    v = (v << ob) | (128'(d) & ((128'd1 << ob) - 128'd1));
    v = v << ib;
    return v;
  endfunction

  logic [127:0] expV [16];
  int           expL [16];
  string        expT [16];
  int           expN;

  task automatic addExp(input logic [7:0] op, input int ab, input logic [31:0] a,
                        input int ob, input logic [31:0] d, input int ib, input string tag);
    expV[expN] = mk(op, ab, a, ob, d, ib);
    expL[expN] = 8 + ab + ob + ib;
    expT[expN] = tag;
    expN++;
  endtask

  task automatic runOp(input logic [1:0] op, input logic [31:0] a, input logic [31:0] d,
                       input logic [2:0] nbIn, input logic m16, input int polls, input bit ignoreTest);
    int nb, ab, waitCnt;
    logic [31:0] prevRd, expRd;
    string cntTag;
    nb = (nbIn >= 1 && nbIn <= 3) ? int'(nbIn) : 4;
    ab = m16 ? 16 : 24;
    expN = 0;
    case (op)
      2'd0: begin addExp(8'h90, 24, 0, 0, 0, 16, "R1"); cntTag = "R1"; end
      2'd1: begin
        addExp(8'h06, 0, 0, 0, 0, 0, "R2");
        addExp(8'h20, 24, {8'h00, a[11:0], 12'h000}, 0, 0, 0, "R3");
        for (int k = 0; k <= polls; k++) addExp(8'h05, 0, 0, 0, 0, 16, "R4");
        cntTag = "R4";
      end
      2'd2: begin addExp(8'h03, ab, a, 0, 0, 8 * nb, "R5"); cntTag = "R5"; end
      default: begin
        addExp(8'h06, 0, 0, 0, 0, 0, "R2");
        addExp(8'h02, ab, a, 8 * nb, d, 0, "R6");
        if (!m16) for (int k = 0; k <= polls; k++) addExp(8'h05, 0, 0, 0, 0, 16, "R4");
        cntTag = m16 ? "R7" : "R4";
      end
    endcase
    @(negedge clk);
    frameCnt = 0;
    busyLeft = polls;
    prevRd = rdData;
    addr16Mode = m16; reqOp = op; reqAddr = a; reqWdata = d; reqBytes = nbIn;
    reqValid = 1'b1;
    #1;
    chk(reqAck == 1'b1, "R10", "ack when idle", 128'(reqAck), 128'd1);
    @(negedge clk);
    reqValid = 1'b0;
    if (ignoreTest) begin
      repeat (3) @(negedge clk);
      reqValid = 1'b1; reqOp = 2'd3;
      #1;
      chk(reqAck == 1'b0 && busy == 1'b1, "R10", "no ack while busy", 128'({reqAck, busy}), 128'b01);
      repeat (5) @(negedge clk);
      reqValid = 1'b0;
    end
    waitCnt = 0;
    while (!doneStb && waitCnt < 20000) begin
      @(negedge clk);
      waitCnt++;
    end
    chk(doneStb == 1'b1, "R10", "done seen", 128'(doneStb), 128'd1);
    chk(frameCnt == expN, cntTag, "frame count", 128'(frameCnt), 128'(expN));
    for (int i = 0; i < expN && i < frameCnt && i < 16; i++)
      chk(logBits[i] == expV[i] && logLen[i] == expL[i], expT[i], "frame content",
          logBits[i], expV[i]);
    if (op == 2'd0) expRd = {16'h0, idWord};
    else if (op == 2'd2) expRd = readWord >> (32 - 8 * nb);
    else expRd = prevRd;
    chk(rdData == expRd, (op == 2'd0) ? "R1" : (op == 2'd2) ? "R5" : "R6", "rdData",
        128'(rdData), 128'(expRd));
    @(negedge clk);
    chk(doneStb == 1'b0 && busy == 1'b0, "R10", "done single pulse", 128'({doneStb, busy}), 128'b00);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    repeat (3) @(negedge clk);
    chk(spiCsN == 1'b1 && spiSclk == 1'b0, "R11", "bus idle in reset", 128'({spiCsN, spiSclk}), 128'b10);
    chk(busy == 1'b0 && doneStb == 1'b0 && reqAck == 1'b0, "R11", "status in reset",
        128'({busy, doneStb, reqAck}), 128'b000);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(rdData == 32'h0 && spiCsN == 1'b1 && busy == 1'b0, "R11", "after reset",
        128'({rdData, spiCsN, busy}), 128'({32'h0, 1'b1, 1'b0}));

    idWord = 16'hEF14;
    runOp(2'd0, 32'h1234_5678, 32'h0, 3'd1, 1'b0, 0, 1'b0);
    idWord = 16'h1C3A;
    runOp(2'd0, 32'h0, 32'h0, 3'd4, 1'b1, 0, 1'b0);

    for (int m = 0; m < 2; m++)
      for (int nb = 0; nb < 8; nb++) begin
        readWord = 32'hC35A_9E01 ^ (32'h1111_1111 * nb) ^ (m ? 32'hFFFF_0000 : 32'h0);
        runOp(2'd2, 32'hA500_1234 + 32'h0001_0101 * nb, 32'h0, 3'(nb), 1'(m), 0, 1'b0);
      end

    for (int m = 0; m < 2; m++)
      for (int nb = 1; nb <= 5; nb++)
        runOp(2'd3, 32'h5A00_4321 + 32'h0002_0010 * nb,
              32'hDEAD_BEEF ^ (32'h0F0F_0F0F * nb), 3'(nb), 1'(m), nb % 4, 1'b0);

    for (int p = 0; p < 4; p++)
      runOp(2'd1, 32'hFFFF_F000 | (32'h0000_0ABC + p), 32'h0, 3'd1, 1'(p & 1), p, 1'b0);

    readWord = 32'h8001_7FFE;
    runOp(2'd2, 32'h0000_BEEF, 32'h0, 3'd2, 1'b0, 0, 1'b1);

    chk(minSetup >= FULL, "R9", "cs setup", 128'(minSetup), 128'(FULL));
    chk(minHold >= FULL, "R9", "cs hold", 128'(minHold), 128'(FULL));
    chk(minGap >= FULL, "R9", "cs gap", 128'(minGap), 128'(FULL));
    chk(minPer == FULL && maxPer == FULL, "R8", "sclk period", 128'({minPer, maxPer}), 128'({FULL, FULL}));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule